// File: doc/BRIEF.md
# DDR SDRAM Command Bus Monitor

This block sits passively on the command pins of a DDR SDRAM channel and classifies every clock's command. It does not drive the bus. Each rising edge it samples the clock enable, the four command strobes, the bank select and the address lines. One cycle later it presents a one-hot command code together with the address fields that matter for that command: the bank, the row (or the mode opcode), the column, the auto-precharge request, the precharge-all flag and which mode register is being written.

It also keeps a small amount of context. A READ or WRITE opens a burst window whose length comes from a configuration input. A BURST TERMINATE is accepted only inside the window of a plain read, which is one issued without auto precharge. The clock enable separates auto refresh from self-refresh entry, and it also marks as misuse any other real command issued while it is low. Each command that is undefined in its context raises a one-cycle violation pulse that is aligned with that command's decoded outputs.

Top module: `ddr_cmd_monitor`

## Requirements
- R1: `cmd_vec` always has exactly one bit set. When `cs_n` is high the command decodes as no-operation (bit 0) whatever the other strobes are, and `cs_n` low with `ras_n`/`cas_n`/`we_n` = 1/1/1 also decodes as bit 0.
- R2: With `cs_n` low, `ras_n`/`cas_n`/`we_n` decode as follows: 0/1/1 activate (bit 1), 1/0/1 read (bit 2), 1/0/0 write (bit 3), 1/1/0 burst terminate (bit 4), 0/1/0 precharge (bit 5), 0/0/0 mode-register load (bit 8).
- R3: The strobe pattern 0/0/1 decodes as auto refresh (bit 6) when `cke` is high and as self-refresh entry (bit 7) when `cke` is low. Any command other than no-operation or refresh that is sampled with `cke` low raises `cmd_violation`.
- R4: For read and write, `cmd_col` = `addr[9:0]`, `cmd_autopre` = `addr[10]` and `cmd_bank` = `ba`. For every other command, `cmd_col` and `cmd_autopre` are zero.
- R5: For activate, `cmd_row` = `addr[12:0]` and `cmd_bank` = `ba`. For precharge, `cmd_pre_all` = `addr[10]`. When that flag is set, `cmd_bank` reads zero, and otherwise it equals `ba`.
- R6: For a mode-register load, `cmd_row` carries the opcode `addr[12:0]` and `cmd_bank` = `ba`. `ba` = 00 gives `cmd_ext_mode` = 0 and `ba` = 01 gives `cmd_ext_mode` = 1. `ba` = 10 or 11 raises `cmd_violation`.
- R7: A command sampled at rising edge N appears on all outputs after edge N+1. A synchronous reset (`rst_n` low at an edge) leaves `cmd_vec` at bit 0, all fields and `cmd_violation` at zero, and no burst window open.
- R8: A read or write opens a burst window covering the next `burst_len` sampled commands. A newer read or write restarts the window with its own type, and a `burst_len` of 0 opens no window.
- R9: A burst terminate is legal only inside the window of a read with `addr[10]` low, and it closes that window. A burst terminate during a write window, during an auto-precharge read window, or with no window open raises `cmd_violation`.
- R10: `cmd_violation` is high only in the output cycle of an offending command, and it is low for every legal command, including the one that immediately follows a violation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Command bus clock; sampled on the rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| cke | input | 1 | Clock enable as seen on the bus |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable strobe, active low |
| ba | input | 2 | Bank select lines |
| addr | input | 13 | Row / column / opcode address lines |
| burst_len | input | 4 | Burst window length, in sampled commands |
| cmd_vec | output | 9 | One-hot decoded command |
| cmd_bank | output | 2 | Decoded bank |
| cmd_row | output | 13 | Row address, or opcode for a mode-register load |
| cmd_col | output | 10 | Column address for read or write |
| cmd_autopre | output | 1 | Auto precharge requested by a read or write |
| cmd_pre_all | output | 1 | Precharge covers all banks |
| cmd_ext_mode | output | 1 | Mode-register load targets the extended register |
| cmd_violation | output | 1 | Command is undefined in its context |

## Verification
Every output belongs to the command that was sampled two rising edges before it is read. The input capture register adds one cycle, and the output register adds a second. The bench drives inputs on falling edges. Before it drives each new vector, it compares the outputs against the expectation for the vector applied two falling edges earlier. Burst-window checks count the commands between a read or write and a burst terminate, because the window advances once per sampled command. The directed tests confirm the two-edge latency itself by reading the previous result one edge after a new command is applied.

// File: rtl/ddr_cmd_pkg.sv
// Shared widths, command codes and field bundle for the DDR command monitor.
// Assumes a 4-bank device with 13 address lines and a 10-bit column.
package ddr_cmd_pkg;

    localparam int BA_W    = 2;
    localparam int ROW_W   = 13;
    localparam int COL_W   = 10;
    localparam int AP_BIT  = 10;
    localparam int BL_W    = 4;
    localparam int NUM_CMD = 9;
    localparam int CMD_W   = $clog2(NUM_CMD);

    // Bit position of each command inside the one-hot output vector.
    typedef enum logic [CMD_W-1:0] {
        CMD_NOP  = 4'd0,
        CMD_ACT  = 4'd1,
        CMD_RD   = 4'd2,
        CMD_WR   = 4'd3,
        CMD_BST  = 4'd4,
        CMD_PRE  = 4'd5,
        CMD_AREF = 4'd6,
        CMD_SREF = 4'd7,
        CMD_LMR  = 4'd8
    } cmd_e;

    // Kind of burst currently owning the data bus.
    typedef enum logic [1:0] {
        BURST_NONE  = 2'd0,
        BURST_RD    = 2'd1,
        BURST_RD_AP = 2'd2,
        BURST_WR    = 2'd3
    } burst_e;

    // Address-derived fields reported with each command.
    typedef struct packed {
        logic [BA_W-1:0]  bank;
        logic [ROW_W-1:0] row;
        logic [COL_W-1:0] col;
        logic             autopre;
        logic             pre_all;
        logic             ext_mode;
    } fields_t;

    localparam logic [BA_W-1:0] BA_MODE_REG = BA_W'(0);
    localparam logic [BA_W-1:0] BA_EXT_REG  = BA_W'(1);

endpackage

// File: rtl/ddr_cmd_capture.sv
// Input capture stage: registers the raw bus pins on every rising edge.
// Assumes the pins are already synchronous to clk. Reset leaves the
// register holding a deselect with the clock enable high.
module ddr_cmd_capture
    import ddr_cmd_pkg::*;
#(
    parameter int BA_WIDTH   = BA_W,
    parameter int ADDR_WIDTH = ROW_W
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cke,
    input  logic                  cs_n,
    input  logic                  ras_n,
    input  logic                  cas_n,
    input  logic                  we_n,
    input  logic [BA_WIDTH-1:0]   ba,
    input  logic [ADDR_WIDTH-1:0] addr,
    output logic                  cke_q,
    output logic                  cs_n_q,
    output logic                  ras_n_q,
    output logic                  cas_n_q,
    output logic                  we_n_q,
    output logic [BA_WIDTH-1:0]   ba_q,
    output logic [ADDR_WIDTH-1:0] addr_q
);

    // Sample the command bus; reset parks it on an idle deselect.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cke_q   <= 1'b1;
            cs_n_q  <= 1'b1;
            ras_n_q <= 1'b1;
            cas_n_q <= 1'b1;
            we_n_q  <= 1'b1;
            ba_q    <= '0;
            addr_q  <= '0;
        end else begin
            cke_q   <= cke;
            cs_n_q  <= cs_n;
            ras_n_q <= ras_n;
            cas_n_q <= cas_n;
            we_n_q  <= we_n;
            ba_q    <= ba;
            addr_q  <= addr;
        end
    end

endmodule

// File: rtl/ddr_cmd_decode.sv
// Combinational decoder: turns one sampled strobe set into a command code,
// its address fields, and the context-free violations (clock enable misuse,
// reserved mode-register select). Burst context is judged elsewhere.
module ddr_cmd_decode
    import ddr_cmd_pkg::*;
(
    input  logic             cke,
    input  logic             cs_n,
    input  logic             ras_n,
    input  logic             cas_n,
    input  logic             we_n,
    input  logic [BA_W-1:0]  ba,
    input  logic [ROW_W-1:0] addr,
    output cmd_e             cmd,
    output fields_t          fld,
    output logic             bad_static,
    output logic             is_bst,
    output logic             rd_start,
    output logic             wr_start
);

    logic bad_lmr_sel;

    // Strobe decode plus per-command field extraction.
    always_comb begin
        cmd         = CMD_NOP;
        fld         = '0;
        bad_lmr_sel = 1'b0;
        if (!cs_n) begin
            case ({ras_n, cas_n, we_n})
                3'b011: begin
                    cmd      = CMD_ACT;
                    fld.bank = ba;
                    fld.row  = addr;
                end
                3'b101: begin
                    cmd         = CMD_RD;
                    fld.bank    = ba;
                    fld.col     = addr[COL_W-1:0];
                    fld.autopre = addr[AP_BIT];
                end
                3'b100: begin
                    cmd         = CMD_WR;
                    fld.bank    = ba;
                    fld.col     = addr[COL_W-1:0];
                    fld.autopre = addr[AP_BIT];
                end
                3'b110: cmd = CMD_BST;
                3'b010: begin
                    cmd         = CMD_PRE;
                    fld.pre_all = addr[AP_BIT];
                    fld.bank    = addr[AP_BIT] ? '0 : ba;
                end
                3'b001: cmd = cke ? CMD_AREF : CMD_SREF;
                3'b000: begin
                    cmd          = CMD_LMR;
                    fld.bank     = ba;
                    fld.row      = addr;
                    fld.ext_mode = (ba == BA_EXT_REG);
                    bad_lmr_sel  = (ba != BA_MODE_REG) && (ba != BA_EXT_REG);
                end
                default: cmd = CMD_NOP;
            endcase
        end
    end

    // Violations that need no history: real command with CKE low, bad select.
    always_comb begin
        bad_static = bad_lmr_sel ||
                     (!cke && (cmd != CMD_NOP) && (cmd != CMD_SREF));
    end

    // Handshake flags for the burst tracker.
    always_comb begin
        is_bst   = (cmd == CMD_BST);
        rd_start = (cmd == CMD_RD) && cke;
        wr_start = (cmd == CMD_WR) && cke;
    end

endmodule

// File: rtl/ddr_burst_tracker.sv
// Burst context tracker: remembers the kind of the last read or write burst
// and counts down its window one sampled command at a time. It reports
// whether a burst terminate arriving now is legal. Assumes burst_len is
// stable while a read or write is being decoded.
module ddr_burst_tracker
    import ddr_cmd_pkg::*;
#(
    parameter int LEN_W = BL_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rd_start,
    input  logic             wr_start,
    input  logic             autopre,
    input  logic             bst_seen,
    input  logic [LEN_W-1:0] burst_len,
    output logic             bst_legal
);

    logic [LEN_W-1:0] remain;
    burst_e           kind;
    logic             open_win;

    // Window state seen by the command being decoded right now.
    always_comb begin
        open_win  = (remain != '0);
        bst_legal = open_win && (kind == BURST_RD);
    end

    // Load on read/write, close on legal terminate, else count down.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            remain <= '0;
            kind   <= BURST_NONE;
        end else if (rd_start || wr_start) begin
            remain <= burst_len;
            if (burst_len == '0)
                kind <= BURST_NONE;
            else if (wr_start)
                kind <= BURST_WR;
            else
                kind <= autopre ? BURST_RD_AP : BURST_RD;
        end else if (bst_seen && bst_legal) begin
            remain <= '0;
            kind   <= BURST_NONE;
        end else if (open_win) begin
            remain <= remain - LEN_W'(1);
            if (remain == LEN_W'(1))
                kind <= BURST_NONE;
        end
    end

    AST_IDLE_HAS_NO_KIND: assert property (@(posedge clk) disable iff (!rst_n)
        (remain == '0) |-> (kind == BURST_NONE)); // R9

    AST_WINDOW_LOADS_LEN: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_start || wr_start) |=> (remain == $past(burst_len))); // R8

endmodule

// File: rtl/ddr_cmd_monitor.sv
// Top of the DDR command monitor. Captures the bus, decodes the command,
// consults the burst tracker for terminate legality and registers all
// results, so outputs trail the sampled command by one clock.
// Assumes a passive tap: nothing here drives the memory bus.
module ddr_cmd_monitor
    import ddr_cmd_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cke,
    input  logic               cs_n,
    input  logic               ras_n,
    input  logic               cas_n,
    input  logic               we_n,
    input  logic [BA_W-1:0]    ba,
    input  logic [ROW_W-1:0]   addr,
    input  logic [BL_W-1:0]    burst_len,
    output logic [NUM_CMD-1:0] cmd_vec,
    output logic [BA_W-1:0]    cmd_bank,
    output logic [ROW_W-1:0]   cmd_row,
    output logic [COL_W-1:0]   cmd_col,
    output logic               cmd_autopre,
    output logic               cmd_pre_all,
    output logic               cmd_ext_mode,
    output logic               cmd_violation
);

    logic             cke_q, cs_n_q, ras_n_q, cas_n_q, we_n_q;
    logic [BA_W-1:0]  ba_q;
    logic [ROW_W-1:0] addr_q;

    cmd_e             dec_cmd;
    fields_t          dec_fld;
    logic             dec_bad, dec_bst, dec_rd, dec_wr;
    logic             bst_ok;
    logic [CMD_W-1:0] cmd_code;
    logic [NUM_CMD-1:0] onehot_d;
    logic             viol_d;

    ddr_cmd_capture u_capture (
        .clk     (clk),
        .rst_n   (rst_n),
        .cke     (cke),
        .cs_n    (cs_n),
        .ras_n   (ras_n),
        .cas_n   (cas_n),
        .we_n    (we_n),
        .ba      (ba),
        .addr    (addr),
        .cke_q   (cke_q),
        .cs_n_q  (cs_n_q),
        .ras_n_q (ras_n_q),
        .cas_n_q (cas_n_q),
        .we_n_q  (we_n_q),
        .ba_q    (ba_q),
        .addr_q  (addr_q)
    );

    ddr_cmd_decode u_decode (
        .cke        (cke_q),
        .cs_n       (cs_n_q),
        .ras_n      (ras_n_q),
        .cas_n      (cas_n_q),
        .we_n       (we_n_q),
        .ba         (ba_q),
        .addr       (addr_q),
        .cmd        (dec_cmd),
        .fld        (dec_fld),
        .bad_static (dec_bad),
        .is_bst     (dec_bst),
        .rd_start   (dec_rd),
        .wr_start   (dec_wr)
    );

    ddr_burst_tracker u_burst (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_start  (dec_rd),
        .wr_start  (dec_wr),
        .autopre   (dec_fld.autopre),
        .bst_seen  (dec_bst),
        .burst_len (burst_len),
        .bst_legal (bst_ok)
    );

    assign cmd_code = dec_cmd;

    // One comparator per command bit builds the one-hot vector.
    for (genvar k = 0; k < NUM_CMD; k++) begin : g_onehot
        assign onehot_d[k] = (cmd_code == CMD_W'(k));
    end

    // Combine static and burst-context violations.
    always_comb viol_d = dec_bad || (dec_bst && !bst_ok);

    // Output register stage; reset shows an idle no-operation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_vec       <= NUM_CMD'(1);
            cmd_bank      <= '0;
            cmd_row       <= '0;
            cmd_col       <= '0;
            cmd_autopre   <= 1'b0;
            cmd_pre_all   <= 1'b0;
            cmd_ext_mode  <= 1'b0;
            cmd_violation <= 1'b0;
        end else begin
            cmd_vec       <= onehot_d;
            cmd_bank      <= dec_fld.bank;
            cmd_row       <= dec_fld.row;
            cmd_col       <= dec_fld.col;
            cmd_autopre   <= dec_fld.autopre;
            cmd_pre_all   <= dec_fld.pre_all;
            cmd_ext_mode  <= dec_fld.ext_mode;
            cmd_violation <= viol_d;
        end
    end

    AST_CMD_ONE_HOT: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(cmd_vec) == 1); // R1

    AST_COL_ONLY_ON_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
        ((cmd_col != '0) || cmd_autopre) |-> (cmd_vec[int'(CMD_RD)] || cmd_vec[int'(CMD_WR)])); // R4

    AST_PREALL_DROPS_BANK: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_pre_all |-> (cmd_vec[int'(CMD_PRE)] && (cmd_bank == '0))); // R5

    AST_EXT_ONLY_ON_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_ext_mode |-> (cmd_vec[int'(CMD_LMR)] && (cmd_bank == BA_EXT_REG))); // R6

endmodule

// File: tb/ddr_cmd_monitor_test.sv
// Bench: table-driven sweep of the command set, then directed latency,
// reset and burst-window corner cases.
module ddr_cmd_monitor_test;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        cke, cs_n, ras_n, cas_n, we_n;
    logic [1:0]  ba;
    logic [12:0] addr;
    logic [3:0]  burst_len;
    logic [8:0]  cmd_vec;
    logic [1:0]  cmd_bank;
    logic [12:0] cmd_row;
    logic [9:0]  cmd_col;
    logic        cmd_autopre, cmd_pre_all, cmd_ext_mode, cmd_violation;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    always #4 clk = ~clk;

    ddr_cmd_monitor uut (
        .clk(clk), .rst_n(rst_n), .cke(cke), .cs_n(cs_n), .ras_n(ras_n),
        .cas_n(cas_n), .we_n(we_n), .ba(ba), .addr(addr), .burst_len(burst_len),
        .cmd_vec(cmd_vec), .cmd_bank(cmd_bank), .cmd_row(cmd_row),
        .cmd_col(cmd_col), .cmd_autopre(cmd_autopre), .cmd_pre_all(cmd_pre_all),
        .cmd_ext_mode(cmd_ext_mode), .cmd_violation(cmd_violation)
    );

    // ctl = {cke, cs_n, ras_n, cas_n, we_n}; eflg = {autopre, pre_all, ext, viol}
    typedef struct packed {
        logic [4:0]  ctl;
        logic [1:0]  ba;
        logic [12:0] addr;
        logic [8:0]  cmd;
        logic [1:0]  eb;
        logic [12:0] erow;
        logic [9:0]  ecol;
        logic [3:0]  eflg;
        logic [3:0]  req;
    } vec_t;

    localparam logic [4:0] C_NOP = 5'b10111;
    localparam logic [4:0] C_RD  = 5'b10101;
    localparam logic [4:0] C_ACT = 5'b10011;
    localparam logic [4:0] C_BST = 5'b10110;

    localparam int NV = 29;
    localparam vec_t VECS [NV] = '{
        '{5'b11000, 2'd3, 13'h1FFF, 9'h001, 2'd0, 13'h0000, 10'h000, 4'b0000, 4'd1},  // R1 deselect
        '{5'b10111, 2'd2, 13'h0ABC, 9'h001, 2'd0, 13'h0000, 10'h000, 4'b0000, 4'd1},  // R1 nop
        '{5'b10011, 2'd2, 13'h1ABC, 9'h002, 2'd2, 13'h1ABC, 10'h000, 4'b0000, 4'd5},  // R5 activate
        '{5'b10101, 2'd2, 13'h0055, 9'h004, 2'd2, 13'h0000, 10'h055, 4'b0000, 4'd4},  // R4 read
        '{5'b10110, 2'd3, 13'h0400, 9'h010, 2'd0, 13'h0000, 10'h000, 4'b0000, 4'd9},  // R9 legal stop
        '{5'b10110, 2'd0, 13'h0000, 9'h010, 2'd0, 13'h0000, 10'h000, 4'b0001, 4'd9},  // R9 no window
        '{5'b10100, 2'd1, 13'h07FF, 9'h008, 2'd1, 13'h0000, 10'h3FF, 4'b1000, 4'd4},  // R4 write+ap
        '{5'b10111, 2'd0, 13'h0000, 9'h001, 2'd0, 13'h0000, 10'h000, 4'b0000, 4'd8},
        '{5'b10110, 2'd0, 13'h0000, 9'h010, 2'd0, 13'h0000, 10'h000, 4'b0001, 4'd9},  // R9 in write
        '{5'b10101, 2'd0, 13'h0412, 9'h004, 2'd0, 13'h0000, 10'h012, 4'b1000, 4'd4},  // R4 read+ap
        '{5'b10110, 2'd0, 13'h0000, 9'h010, 2'd0, 13'h0000, 10'h000, 4'b0001, 4'd9},  // R9 ap read
        '{5'b10010, 2'd3, 13'h0400, 9'h020, 2'd0, 13'h0000, 10'h000, 4'b0100, 4'd5},  // R5 pre all
        '{5'b10010, 2'd3, 13'h0000, 9'h020, 2'd3, 13'h0000, 10'h000, 4'b0000, 4'd5},  // R5 pre one
        '{5'b10001, 2'd1, 13'h1234, 9'h040, 2'd0, 13'h0000, 10'h000, 4'b0000, 4'd3},  // R3 auto
        '{5'b00001, 2'd0, 13'h0000, 9'h080, 2'd0, 13'h0000, 10'h000, 4'b0000, 4'd3},  // R3 self
        '{5'b00011, 2'd1, 13'h0005, 9'h002, 2'd1, 13'h0005, 10'h000, 4'b0001, 4'd3},  // R3 cke low
        '{5'b01111, 2'd0, 13'h0000, 9'h001, 2'd0, 13'h0000, 10'h000, 4'b0000, 4'd10}, // R10 pulse
        '{5'b10000, 2'd0, 13'h0123, 9'h100, 2'd0, 13'h0123, 10'h000, 4'b0000, 4'd6},  // R6 mode
        '{5'b10000, 2'd1, 13'h0002, 9'h100, 2'd1, 13'h0002, 10'h000, 4'b0010, 4'd6},  // R6 ext
        '{5'b10000, 2'd2, 13'h0010, 9'h100, 2'd2, 13'h0010, 10'h000, 4'b0001, 4'd6},  // R6 bad
        '{5'b10000, 2'd3, 13'h1FFF, 9'h100, 2'd3, 13'h1FFF, 10'h000, 4'b0001, 4'd6},  // R6 bad
        '{5'b10101, 2'd1, 13'h0001, 9'h004, 2'd1, 13'h0000, 10'h001, 4'b0000, 4'd4},
        '{5'b10111, 2'd0, 13'h0000, 9'h001, 2'd0, 13'h0000, 10'h000, 4'b0000, 4'd8},
        '{5'b10111, 2'd0, 13'h0000, 9'h001, 2'd0, 13'h0000, 10'h000, 4'b0000, 4'd8},
        '{5'b10110, 2'd0, 13'h0000, 9'h010, 2'd0, 13'h0000, 10'h000, 4'b0001, 4'd8},  // R8 expired
        '{5'b10100, 2'd0, 13'h0000, 9'h008, 2'd0, 13'h0000, 10'h000, 4'b0000, 4'd2},  // R2 write
        '{5'b10101, 2'd0, 13'h0003, 9'h004, 2'd0, 13'h0000, 10'h003, 4'b0000, 4'd8},  // R8 restart
        '{5'b10110, 2'd0, 13'h0000, 9'h010, 2'd0, 13'h0000, 10'h000, 4'b0000, 4'd8},  // R8 legal
        '{5'b10111, 2'd0, 13'h0000, 9'h001, 2'd0, 13'h0000, 10'h000, 4'b0000, 4'd10}  // R10 clear
    };

    function automatic logic [37:0] pk(logic [8:0] c, logic [1:0] b, logic [12:0] r,
                                       logic [9:0] col, logic [3:0] f);
        return {c, b, r, col, f};
    endfunction

    task automatic drive(input logic [4:0] ctl, input logic [1:0] b, input logic [12:0] a);
        {cke, cs_n, ras_n, cas_n, we_n} = ctl;
        ba   = b;
        addr = a;
    endtask

    task automatic chk(input int req, input logic [37:0] exp_v);
        logic [37:0] got;
        got = {cmd_vec, cmd_bank, cmd_row, cmd_col,
               cmd_autopre, cmd_pre_all, cmd_ext_mode, cmd_violation};
        n_checks++;
        if (got !== exp_v) begin
            n_fails++;
            $display("FAIL R%0d: got %h expected %h", req, got, exp_v);
        end
    endtask

    task automatic step(input logic [4:0] ctl, input logic [1:0] b, input logic [12:0] a);
        @(negedge clk);
        drive(ctl, b, a);
    endtask

    localparam logic [37:0] IDLE = {9'h001, 29'd0};

    initial begin
        rst_n = 1'b0;
        burst_len = 4'd2;
        drive(5'b11111, 2'd0, 13'h0000);
        repeat (3) @(negedge clk);
        chk(7, IDLE); // R7 reset state
        rst_n = 1'b1;

        // Table walk: result of vector i-2 is due at the falling edge where i is applied.
        for (int i = 0; i < NV + 2; i++) begin
            @(negedge clk);
            if (i >= 2)
                chk(int'(VECS[i-2].req), pk(VECS[i-2].cmd, VECS[i-2].eb, VECS[i-2].erow,
                                             VECS[i-2].ecol, VECS[i-2].eflg));
            if (i < NV) drive(VECS[i].ctl, VECS[i].ba, VECS[i].addr);
            else        drive(C_NOP, 2'd0, 13'h0000);
        end

        // R7 latency: one edge after apply the old result still shows.
        step(C_ACT, 2'd1, 13'h0AAA);
        step(C_NOP, 2'd0, 13'h0000);
        chk(7, IDLE);
        @(negedge clk);
        chk(7, pk(9'h002, 2'd1, 13'h0AAA, 10'h000, 4'b0000));

        // R7 reset mid-burst clears outputs and the window (R9 afterwards).
        step(C_RD, 2'd0, 13'h0000);
        step(C_NOP, 2'd0, 13'h0000);
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk(7, IDLE);
        rst_n = 1'b1;
        drive(C_BST, 2'd0, 13'h0000);
        step(C_NOP, 2'd0, 13'h0000);
        @(negedge clk);
        chk(9, pk(9'h010, 2'd0, 13'h0000, 10'h000, 4'b0001));

        // R8 window of four: terminate as fourth command after read is legal.
        burst_len = 4'd4;
        step(C_RD, 2'd0, 13'h0000);
        step(C_NOP, 2'd0, 13'h0000);
        step(C_NOP, 2'd0, 13'h0000);
        step(C_NOP, 2'd0, 13'h0000);
        step(C_BST, 2'd0, 13'h0000);
        step(C_NOP, 2'd0, 13'h0000);
        @(negedge clk);
        chk(8, pk(9'h010, 2'd0, 13'h0000, 10'h000, 4'b0000));
        // R9 the legal terminate closed the window.
        step(C_BST, 2'd0, 13'h0000);
        step(C_NOP, 2'd0, 13'h0000);
        @(negedge clk);
        chk(9, pk(9'h010, 2'd0, 13'h0000, 10'h000, 4'b0001));

        // R8 fifth command after a four-long window is outside it.
        step(C_RD, 2'd0, 13'h0000);
        step(C_NOP, 2'd0, 13'h0000);
        step(C_NOP, 2'd0, 13'h0000);
        step(C_NOP, 2'd0, 13'h0000);
        step(C_NOP, 2'd0, 13'h0000);
        step(C_BST, 2'd0, 13'h0000);
        step(C_NOP, 2'd0, 13'h0000);
        @(negedge clk);
        chk(8, pk(9'h010, 2'd0, 13'h0000, 10'h000, 4'b0001));

        // R8 zero length opens no window.
        burst_len = 4'd0;
        step(C_RD, 2'd0, 13'h0000);
        step(C_BST, 2'd0, 13'h0000);
        step(C_NOP, 2'd0, 13'h0000);
        @(negedge clk);
        chk(8, pk(9'h010, 2'd0, 13'h0000, 10'h000, 4'b0001));

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: got hung run expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    end

endmodule